// File: doc/BRIEF.md
# DDR3 Power-Up Initialization Sequencer

This block sits on the controller side of a DDR3 memory interface. It brings the memory from power-up to a state where normal commands can go out. After a synchronous reset or a restart request, it holds the memory reset pin active. It then releases reset while clock-enable stays low, and raises clock-enable. Next it writes the four mode registers in the order the memory requires, issues a long ZQ calibration, and waits out the DLL-lock and calibration times. At that point it raises a sticky done flag.

Every interval is a parameter counted in clock cycles. A system integrator sets these from the real microsecond and nanosecond limits at the chosen clock rate. A testbench can shrink them to a few cycles. The mode register contents come in on four configuration buses. The sequencer passes them to the address lines when it writes each register. It forces the two bits that initialization depends on: DLL enabled in MR1, and DLL reset in MR0.

Top module: `ddr3_powerup_seq`

## Requirements
- R1: While `rst` is high, and for the first T_RSTL cycles after `rst` or `restart` is released, `mem_reset_n` is 0, `mem_cke` is 0 and `init_done` is 0.
- R2: `mem_reset_n` goes to 1 after exactly T_RSTL cycles. `mem_cke` stays 0 for exactly T_CKEL further cycles, so clock-enable is already low when reset is released.
- R3: `mem_cke` goes to 1 after those T_CKEL cycles. It stays 1 continuously until a restart.
- R4: `mem_odt` is driven 0 in every cycle.
- R5: In every cycle that is not a command cycle, the command bus carries NOP (cs_n, ras_n, cas_n, we_n = 0,1,1,1), with `mem_ba` = 0 and `mem_addr` = 0.
- R6: Exactly T_XPR cycles after `mem_cke` rises, a mode-register-set command (0,0,0,0) goes out with `mem_ba` = 3'b010 and `mem_addr` = `mr2_cfg`.
- R7: Further mode-register-set commands follow, each exactly T_MRD cycles after the previous one: first `mem_ba` = 3'b011 with `mr3_cfg`, then 3'b001, then 3'b000.
- R8: The write with `mem_ba` = 3'b001 carries `mr1_cfg` with address bit 0 forced to 0 (DLL enabled). The write with `mem_ba` = 3'b000 carries `mr0_cfg` with address bit 8 forced to 1 (DLL reset).
- R9: Exactly T_MOD cycles after the last mode-register write, a ZQ long calibration command goes out: (0,1,1,0), with address bit 10 = 1, all other address bits 0, and `mem_ba` = 0.
- R10: `init_done` rises exactly max(T_DLLK − T_MOD, T_ZQINIT) cycles after the ZQ command. It therefore comes at least T_DLLK cycles after the DLL reset and at least T_ZQINIT cycles after calibration starts. It then stays 1 until a restart.
- R11: A one-cycle `restart` pulse at any point, including after `init_done`, returns the block to the R1 state. The full sequence R1–R10 then runs again, using the configuration values present at that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| restart | input | 1 | Synchronous request to rerun initialization from the reset phase |
| mr0_cfg | input | ADDR_W | MR0 contents (DLL reset bit forced on) |
| mr1_cfg | input | ADDR_W | MR1 contents (DLL-disable bit forced off) |
| mr2_cfg | input | ADDR_W | MR2 contents |
| mr3_cfg | input | ADDR_W | MR3 contents |
| mem_reset_n | output | 1 | Memory reset, active low |
| mem_cke | output | 1 | Memory clock enable |
| mem_odt | output | 1 | On-die termination control, held low |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | 3 | Bank address (selects mode register) |
| mem_addr | output | ADDR_W | Address lines (mode register data / ZQ long bit) |
| init_done | output | 1 | Sticky flag: memory ready for normal commands |

## Verification
A wrong phase register or a miscounted interval moves one of the pin edges or command cycles by at least one cycle. Examples are the reset release, the clock-enable rise, any of the five command slots, or the done flag. The cycle-exact comparison therefore reports it in the very cycle the edge is misplaced, long before `init_done`. A wrong bank code, a lost forced bit or a swapped register order shows up in the address or bank lines of that one command cycle. A stuck phase shows as `init_done` never rising within the expected cycle. Two configurations are swept: one where the DLL-lock time dominates the final wait and one where calibration does, with restarts both mid-sequence and after completion.

// File: rtl/ddr3_init_pkg.sv
package ddr3_init_pkg;

    // Sequencer phases, in the order they are visited.
    typedef enum logic [3:0] {
        PH_RST_LOW,
        PH_CKE_LOW,
        PH_XPR,
        PH_MR2,
        PH_MR3,
        PH_MR1,
        PH_MR0,
        PH_ZQCL,
        PH_DONE
    } phase_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } bus_cmd_t;

    typedef struct packed {
        logic     reset_n;
        logic     cke;
        logic     odt;
        bus_cmd_t cmd;
        logic [2:0] ba;
        logic     done;
    } pin_ctl_t;

    localparam bus_cmd_t CMD_NOP  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam bus_cmd_t CMD_MRS  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
    localparam bus_cmd_t CMD_ZQCL = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b0};

    localparam logic [2:0] BA_MR0 = 3'b000;
    localparam logic [2:0] BA_MR1 = 3'b001;
    localparam logic [2:0] BA_MR2 = 3'b010;
    localparam logic [2:0] BA_MR3 = 3'b011;

    localparam int unsigned DLL_OFF_BIT   = 0;
    localparam int unsigned DLL_RESET_BIT = 8;
    localparam int unsigned ZQ_LONG_BIT   = 10;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic phase_e phase_after(input phase_e p);
        case (p)
            PH_RST_LOW: return PH_CKE_LOW;
            PH_CKE_LOW: return PH_XPR;
            PH_XPR:     return PH_MR2;
            PH_MR2:     return PH_MR3;
            PH_MR3:     return PH_MR1;
            PH_MR1:     return PH_MR0;
            PH_MR0:     return PH_ZQCL;
            default:    return PH_DONE;
        endcase
    endfunction

endpackage

// File: rtl/ddr3_init_timer.sv
module ddr3_init_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    // Down-counter: a load of D-1 expires after D cycles in the phase.
    always_ff @(posedge clk) begin
        if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/ddr3_init_fsm.sv
module ddr3_init_fsm
    import ddr3_init_pkg::*;
#(
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned T_RSTL  = 8,
    parameter int unsigned T_CKEL  = 8,
    parameter int unsigned T_XPR   = 8,
    parameter int unsigned T_MRD   = 4,
    parameter int unsigned T_MOD   = 12,
    parameter int unsigned T_FINAL = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             expired,
    output phase_e           phase,
    output logic             first,
    output logic             load,
    output logic [CNT_W-1:0] load_val
);
    localparam logic [CNT_W-1:0] L_RSTL  = CNT_W'(T_RSTL - 1);
    localparam logic [CNT_W-1:0] L_CKEL  = CNT_W'(T_CKEL - 1);
    localparam logic [CNT_W-1:0] L_XPR   = CNT_W'(T_XPR - 1);
    localparam logic [CNT_W-1:0] L_MRD   = CNT_W'(T_MRD - 1);
    localparam logic [CNT_W-1:0] L_MOD   = CNT_W'(T_MOD - 1);
    localparam logic [CNT_W-1:0] L_FINAL = CNT_W'(T_FINAL - 1);

    phase_e phase_q, phase_d;
    logic   first_q;
    logic   advance;

    function automatic logic [CNT_W-1:0] span_of(input phase_e p);
        case (p)
            PH_RST_LOW: return L_RSTL;
            PH_CKE_LOW: return L_CKEL;
            PH_XPR:     return L_XPR;
            PH_MR2,
            PH_MR3,
            PH_MR1:     return L_MRD;
            PH_MR0:     return L_MOD;
            PH_ZQCL:    return L_FINAL;
            default:    return '0;
        endcase
    endfunction

    assign advance = expired && (phase_q != PH_DONE);

    always_comb begin
        if (rst || restart) begin
            phase_d = PH_RST_LOW;
        end else if (advance) begin
            phase_d = phase_after(phase_q);
        end else begin
            phase_d = phase_q;
        end
    end

    assign load     = rst || restart || advance;
    assign load_val = span_of(phase_d);

    always_ff @(posedge clk) begin
        phase_q <= phase_d;
        first_q <= load;
    end

    assign phase = phase_q;
    assign first = first_q;

    // R7: phases are only ever visited in their fixed order
    assert_phase_order_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(restart) && (phase_q != $past(phase_q)))
            |-> (phase_q == phase_after($past(phase_q))));

    // R10: the done phase is absorbing until a restart
    assert_done_absorbing_R10: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_DONE && !restart) |=> (phase_q == PH_DONE));
endmodule

// File: rtl/ddr3_init_cmdgen.sv
module ddr3_init_cmdgen
    import ddr3_init_pkg::*;
#(
    parameter int unsigned ADDR_W = 14
) (
    input  phase_e            phase,
    input  logic              first,
    input  logic [ADDR_W-1:0] mr0_cfg,
    input  logic [ADDR_W-1:0] mr1_cfg,
    input  logic [ADDR_W-1:0] mr2_cfg,
    input  logic [ADDR_W-1:0] mr3_cfg,
    output pin_ctl_t          ctl,
    output logic [ADDR_W-1:0] addr
);
    // Commands are placed only in the first cycle of their phase;
    // the remaining cycles of the phase are the spacing wait.
    always_comb begin
        ctl.reset_n = (phase != PH_RST_LOW);
        ctl.cke     = !(phase inside {PH_RST_LOW, PH_CKE_LOW});
        ctl.odt     = 1'b0;
        ctl.cmd     = CMD_NOP;
        ctl.ba      = '0;
        ctl.done    = (phase == PH_DONE);
        addr        = '0;
        if (first) begin
            case (phase)
                PH_MR2: begin
                    ctl.cmd = CMD_MRS;
                    ctl.ba  = BA_MR2;
                    addr    = mr2_cfg;
                end
                PH_MR3: begin
                    ctl.cmd = CMD_MRS;
                    ctl.ba  = BA_MR3;
                    addr    = mr3_cfg;
                end
                PH_MR1: begin
                    ctl.cmd = CMD_MRS;
                    ctl.ba  = BA_MR1;
                    addr    = mr1_cfg;
                    addr[DLL_OFF_BIT] = 1'b0;
                end
                PH_MR0: begin
                    ctl.cmd = CMD_MRS;
                    ctl.ba  = BA_MR0;
                    addr    = mr0_cfg;
                    addr[DLL_RESET_BIT] = 1'b1;
                end
                PH_ZQCL: begin
                    ctl.cmd = CMD_ZQCL;
                    addr[ZQ_LONG_BIT] = 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ddr3_powerup_seq.sv
module ddr3_powerup_seq
    import ddr3_init_pkg::*;
#(
    parameter int unsigned ADDR_W   = 14,
    parameter int unsigned T_RSTL   = 133334,
    parameter int unsigned T_CKEL   = 333333,
    parameter int unsigned T_XPR    = 180,
    parameter int unsigned T_MRD    = 4,
    parameter int unsigned T_MOD    = 12,
    parameter int unsigned T_DLLK   = 512,
    parameter int unsigned T_ZQINIT = 512
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic [ADDR_W-1:0] mr0_cfg,
    input  logic [ADDR_W-1:0] mr1_cfg,
    input  logic [ADDR_W-1:0] mr2_cfg,
    input  logic [ADDR_W-1:0] mr3_cfg,
    output logic              mem_reset_n,
    output logic              mem_cke,
    output logic              mem_odt,
    output logic              mem_cs_n,
    output logic              mem_ras_n,
    output logic              mem_cas_n,
    output logic              mem_we_n,
    output logic [2:0]        mem_ba,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              init_done
);
    // Final wait covers whatever remains of DLL lock after tMOD, and ZQ init.
    localparam int unsigned DLL_REST = (T_DLLK > T_MOD) ? (T_DLLK - T_MOD) : 1;
    localparam int unsigned T_FINAL  = max_u(DLL_REST, T_ZQINIT);
    localparam int unsigned MAX_DUR  = max_u(max_u(max_u(T_RSTL, T_CKEL), max_u(T_XPR, T_MRD)),
                                             max_u(T_MOD, T_FINAL));
    localparam int unsigned CNT_W    = $clog2(MAX_DUR + 1);
    localparam int unsigned GAP_SAT  = max_u(T_MRD, T_MOD);
    localparam int unsigned GAP_W    = $clog2(GAP_SAT + 1);

    phase_e           phase;
    logic             first;
    logic             load;
    logic             expired;
    logic [CNT_W-1:0] load_val;
    pin_ctl_t         ctl;

    ddr3_init_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    ddr3_init_fsm #(
        .CNT_W   (CNT_W),
        .T_RSTL  (T_RSTL),
        .T_CKEL  (T_CKEL),
        .T_XPR   (T_XPR),
        .T_MRD   (T_MRD),
        .T_MOD   (T_MOD),
        .T_FINAL (T_FINAL)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .restart  (restart),
        .expired  (expired),
        .phase    (phase),
        .first    (first),
        .load     (load),
        .load_val (load_val)
    );

    ddr3_init_cmdgen #(.ADDR_W(ADDR_W)) u_cmd (
        .phase   (phase),
        .first   (first),
        .mr0_cfg (mr0_cfg),
        .mr1_cfg (mr1_cfg),
        .mr2_cfg (mr2_cfg),
        .mr3_cfg (mr3_cfg),
        .ctl     (ctl),
        .addr    (mem_addr)
    );

    assign mem_reset_n = ctl.reset_n;
    assign mem_cke     = ctl.cke;
    assign mem_odt     = ctl.odt;
    assign mem_cs_n    = ctl.cmd.cs_n;
    assign mem_ras_n   = ctl.cmd.ras_n;
    assign mem_cas_n   = ctl.cmd.cas_n;
    assign mem_we_n    = ctl.cmd.we_n;
    assign mem_ba      = ctl.ba;
    assign init_done   = ctl.done;

    // Guard logic: cycles since the last non-NOP command, and ZQ seen.
    localparam logic [GAP_W-1:0] GAP_TOP = GAP_W'(GAP_SAT);
    localparam logic [GAP_W-1:0] GAP_MRD = GAP_W'(T_MRD);
    localparam logic [GAP_W-1:0] GAP_MOD = GAP_W'(T_MOD);

    logic             is_mrs, is_zq;
    logic [GAP_W-1:0] gap_q;
    logic             zq_seen_q;

    assign is_mrs = ({mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} == 4'b0000);
    assign is_zq  = ({mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} == 4'b0110);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            gap_q     <= GAP_TOP;
            zq_seen_q <= 1'b0;
        end else begin
            if (is_mrs || is_zq) begin
                gap_q <= GAP_W'(1);
            end else if (gap_q < GAP_TOP) begin
                gap_q <= gap_q + GAP_W'(1);
            end
            if (is_zq) begin
                zq_seen_q <= 1'b1;
            end
        end
    end

    assert_cke_low_in_reset_R2: assert property (@(posedge clk) disable iff (rst)
        !mem_reset_n |-> !mem_cke);

    assert_release_with_cke_low_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_reset_n) |-> !mem_cke);

    assert_cke_held_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_cke && !restart) |=> mem_cke);

    assert_mrs_spacing_R7: assert property (@(posedge clk) disable iff (rst)
        is_mrs |-> (gap_q >= GAP_MRD));

    assert_mrs_needs_cke_R6: assert property (@(posedge clk) disable iff (rst)
        (is_mrs || is_zq) |-> (mem_cke && mem_reset_n));

    assert_zq_spacing_R9: assert property (@(posedge clk) disable iff (rst)
        is_zq |-> (gap_q >= GAP_MOD));

    assert_done_after_zq_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(init_done) |-> zq_seen_q);

    assert_done_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (init_done && !restart) |=> init_done);

    assert_restart_returns_R11: assert property (@(posedge clk) disable iff (rst)
        restart |=> (!mem_reset_n && !mem_cke && !init_done));
endmodule

// File: tb/test_ddr3_powerup_seq.sv
module test_ddr3_powerup_seq;
    localparam int AW = 14;

    // Configuration A: DLL lock dominates the final wait (40-12=28 > 16)
    localparam int A_RSTL = 6, A_CKEL = 5, A_XPR = 7, A_MRD = 4, A_MOD = 12, A_DLLK = 40, A_ZQ = 16;
    localparam int A_FIN  = 28;
    // Configuration B: ZQ init dominates (30 > 20-5=15), back-to-back MRS
    localparam int B_RSTL = 3, B_CKEL = 9, B_XPR = 2, B_MRD = 1, B_MOD = 5, B_DLLK = 20, B_ZQ = 30;
    localparam int B_FIN  = 30;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic restart = 1'b0;
    logic [AW-1:0] mr0, mr1, mr2, mr3;

    logic a_rn, a_ck, a_odt, a_cs, a_ras, a_cas, a_we, a_done;
    logic [2:0] a_ba;
    logic [AW-1:0] a_addr;
    logic b_rn, b_ck, b_odt, b_cs, b_ras, b_cas, b_we, b_done;
    logic [2:0] b_ba;
    logic [AW-1:0] b_addr;

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    ddr3_powerup_seq #(.ADDR_W(AW), .T_RSTL(A_RSTL), .T_CKEL(A_CKEL), .T_XPR(A_XPR),
        .T_MRD(A_MRD), .T_MOD(A_MOD), .T_DLLK(A_DLLK), .T_ZQINIT(A_ZQ)) i_ddr3_powerup_seq (
        .clk(clk), .rst(rst), .restart(restart),
        .mr0_cfg(mr0), .mr1_cfg(mr1), .mr2_cfg(mr2), .mr3_cfg(mr3),
        .mem_reset_n(a_rn), .mem_cke(a_ck), .mem_odt(a_odt), .mem_cs_n(a_cs),
        .mem_ras_n(a_ras), .mem_cas_n(a_cas), .mem_we_n(a_we), .mem_ba(a_ba),
        .mem_addr(a_addr), .init_done(a_done));

    ddr3_powerup_seq #(.ADDR_W(AW), .T_RSTL(B_RSTL), .T_CKEL(B_CKEL), .T_XPR(B_XPR),
        .T_MRD(B_MRD), .T_MOD(B_MOD), .T_DLLK(B_DLLK), .T_ZQINIT(B_ZQ)) i_ddr3_powerup_seq_zq (
        .clk(clk), .rst(rst), .restart(restart),
        .mr0_cfg(mr0), .mr1_cfg(mr1), .mr2_cfg(mr2), .mr3_cfg(mr3),
        .mem_reset_n(b_rn), .mem_cke(b_ck), .mem_odt(b_odt), .mem_cs_n(b_cs),
        .mem_ras_n(b_ras), .mem_cas_n(b_cas), .mem_we_n(b_we), .mem_ba(b_ba),
        .mem_addr(b_addr), .init_done(b_done));

    // Bit layout: 24 reset_n, 23 cke, 22 odt, 21:18 cmd, 17:15 ba, 14:1 addr, 0 done
    task automatic check_dut(input int n, input string run, input string dut, input logic [24:0] act,
                             input int trstl, input int tckel, input int txpr, input int tmrd,
                             input int tmod, input int tfin);
        int b1, b2, b3, b4, b5, b6, b7, b8;
        logic [3:0] c;
        logic [2:0] b;
        logic [AW-1:0] a;
        logic [24:0] exp_v, diff;
        string tag;
        b1 = trstl; b2 = b1 + tckel; b3 = b2 + txpr; b4 = b3 + tmrd;
        b5 = b4 + tmrd; b6 = b5 + tmrd; b7 = b6 + tmod; b8 = b7 + tfin;
        c = 4'b0111; b = 3'b000; a = '0;
        if (n == b3) begin c = 4'b0000; b = 3'b010; a = mr2; end
        if (n == b4) begin c = 4'b0000; b = 3'b011; a = mr3; end
        if (n == b5) begin c = 4'b0000; b = 3'b001; a = mr1 & ~AW'(1); end
        if (n == b6) begin c = 4'b0000; b = 3'b000; a = mr0 | AW'(1 << 8); end
        if (n == b7) begin c = 4'b0110; b = 3'b000; a = AW'(1 << 10); end
        exp_v = {(n >= b1), (n >= b2), 1'b0, c, b, a, (n >= b8)};
        vectors++;
        if (act !== exp_v) begin
            diff = act ^ exp_v;
            if (diff[22])          tag = "R4";
            else if (diff[0])      tag = "R10";
            else if (n < b1)       tag = "R1";
            else if (n < b2)       tag = "R2";
            else if (diff[23])     tag = "R3";
            else if (n == b3)      tag = "R6";
            else if (n == b4)      tag = "R7";
            else if (n == b5 || n == b6) tag = "R8";
            else if (n == b7)      tag = "R9";
            else                   tag = "R5";
            miscompares++;
            $display("FAIL %s [%s %s cycle %0d] actual=%h expected=%h", tag, run, dut, n, act, exp_v);
        end
    endtask

    task automatic check_both(input int n, input string run);
        check_dut(n, run, "A", {a_rn, a_ck, a_odt, a_cs, a_ras, a_cas, a_we, a_ba, a_addr, a_done},
                  A_RSTL, A_CKEL, A_XPR, A_MRD, A_MOD, A_FIN);
        check_dut(n, run, "B", {b_rn, b_ck, b_odt, b_cs, b_ras, b_cas, b_we, b_ba, b_addr, b_done},
                  B_RSTL, B_CKEL, B_XPR, B_MRD, B_MOD, B_FIN);
    endtask

    // Called right after the cycle-0 inputs are driven at a falling edge.
    task automatic sweep(input int ncyc, input string run);
        for (int n = 0; n < ncyc; n++) begin
            #1;
            check_both(n, run);
            @(negedge clk);
        end
    endtask

    task automatic pulse_restart();
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            miscompares++;
            $display("FAIL R10 watchdog expired actual=%0d cycles expected<=20000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        mr0 = 14'h1234; mr1 = 14'h0045; mr2 = 14'h0018; mr3 = 14'h0004;
        // R1: state held while reset is asserted
        repeat (3) @(negedge clk);
        #1;
        check_both(0, "R1 hold");
        @(negedge clk);
        rst = 1'b0;
        // R1..R10: full sequence from reset release
        sweep(80, "power-up");
        // R11 + R8: restart after done, all-ones config (bit 0 of MR1 cleared)
        mr0 = 14'h3FFF; mr1 = 14'h3FFF; mr2 = 14'h3FFF; mr3 = 14'h2AAA;
        pulse_restart();
        sweep(20, "R11 after-done");
        // R11: restart in the middle of the sequence, all-zero config (MR0 bit 8 set)
        mr0 = 14'h0000; mr1 = 14'h0000; mr2 = 14'h0000; mr3 = 14'h0000;
        pulse_restart();
        sweep(80, "R11 mid-sequence");
        // R6/R7: a further pattern to separate the four register slots
        mr0 = 14'h0EFF; mr1 = 14'h1001; mr2 = 14'h0240; mr3 = 14'h0003;
        pulse_restart();
        sweep(80, "R11 pattern");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule